// File: doc/BRIEF.md
# Pause-Aware Refresh Scheduler

This block schedules DRAM refresh for one rank on the controller side. It keeps a count of refresh obligations that goes up once per refresh interval. It decides when to spend those obligations, and it drives one refresh-enable line to the devices. Demand reads win over refresh while the backlog is below its limit. An idle rank with a pending obligation starts, or picks up again, a refresh at once.

A refresh covers a bundle of rows. Its full duration is split into equal quanta, and the boundaries between rows are the points where the device may stop. When a read is waiting while a refresh is running, the scheduler drops the enable line one cycle before the next boundary. The device halts at that boundary. Raising the line again later continues the same refresh with the rows that remain.

An elapsed-time counter moves only while the line is high. When it reaches the full refresh time, the obligation is retired and the counter clears. Once the backlog hits its limit, the refresh is forced: it starts or resumes regardless of reads and runs to completion without pausing.

Top module: `refresh_pause_sched`

## Requirements
- R1: After reset `ref_en`, `ref_paused`, `ref_forced` and `overflow_err` are 0 and `pend_cnt` is 0.
- R2: Every `REFI_CYCLES` strobed cycles (`tick`=1), `pend_cnt` goes up by one, unless it already equals `MAX_PENDING`. In the same cycle, a completing refresh takes one away.
- R3: In a strobed cycle where no refresh is in service, `pend_cnt` > 0, `rank_idle`=1 and `rd_pend`=0, `ref_en` rises on the next clock edge.
- R4: An uninterrupted refresh keeps `ref_en` high for exactly `RFC_CYCLES` strobed cycles. It then drops, and `pend_cnt` decreases by one.
- R5: A pause happens in the strobed cycle where the elapsed count equals k*Q-1. Here Q = `RFC_CYCLES`/`ROWS` and k is 1 to `ROWS`-1, and the condition also needs `rd_pend`=1 and `pend_cnt` < `MAX_PENDING`. `ref_en` then falls on the next edge and `ref_paused` goes to 1.
- R6: `rd_pend`=1 at any other elapsed count has no effect; `ref_en` stays high.
- R7: A paused refresh resumes (`ref_en` high, `ref_paused` 0) in the cycle after a strobe with `rank_idle`=1 and `rd_pend`=0. It stays high only for the remaining strobed cycles, so the total across all its pieces is `RFC_CYCLES`.
- R8: When `pend_cnt` equals `MAX_PENDING`, a refresh starts or resumes regardless of `rd_pend`. While it runs, `ref_forced` is 1 and it is never paused.
- R9: An interval expiry while `pend_cnt` = `MAX_PENDING`, with no completion in the same cycle, sets `overflow_err`. The flag stays set until reset.
- R10: In a cycle with `tick`=0, no output or internal count changes.
- R11: While `rd_pend`=1 and `pend_cnt` < `MAX_PENDING`, no refresh starts or resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Memory-cycle strobe; all counting and decisions happen on strobed cycles |
| rd_pend | input | 1 | A demand read for this rank is waiting |
| rank_idle | input | 1 | Rank has no command activity in flight |
| ref_en | output | 1 | Refresh-enable line to the devices |
| ref_paused | output | 1 | A refresh is halted at a row boundary |
| ref_forced | output | 1 | The refresh in service runs with the backlog at its limit |
| pend_cnt | output | $clog2(MAX_PENDING+1) | Outstanding refresh obligations |
| overflow_err | output | 1 | Sticky: an interval expired with the backlog already full |

## Verification
The main instance is built with REFI_CYCLES=20, RFC_CYCLES=16, ROWS=4 and MAX_PENDING=8. With these values the quantum is 4 cycles, there are three pause points, and a full backlog, and so a forced refresh, is reached within a couple of hundred cycles. A second instance uses REFI_CYCLES=10, which is shorter than the refresh time. Under a permanent read load its backlog saturates, so the overflow flag can actually be reached. Random strobe gaps, reads and idle phases run against a cycle model in the bench. Directed sequences cover pausing at a row boundary, the resume length and the forced run.

// File: rtl/rfp_pkg.sv
package rfp_pkg;

    typedef enum logic [1:0] {
        RS_IDLE   = 2'd0,
        RS_ACTIVE = 2'd1,
        RS_PAUSED = 2'd2
    } rf_state_e;

    typedef struct packed {
        logic last;   // elapsed count is on its final cycle
        logic slot;   // elapsed count is one before a row boundary
    } rf_progress_t;

    typedef struct packed {
        logic have;   // at least one obligation outstanding
        logic full;   // backlog at its limit
    } rf_backlog_t;

    function automatic int quantum_of(input int rfc, input int rows);
        return rfc / rows;
    endfunction

    function automatic int width_of(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/rfp_interval_ctr.sv
module rfp_interval_ctr #(
    parameter int REFI_CYCLES = 3120
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    output logic expire
);
    import rfp_pkg::*;

    localparam int IW = width_of(REFI_CYCLES);

    logic [IW-1:0] cnt;
    logic          at_end;

    assign at_end = (cnt == IW'(REFI_CYCLES - 1));
    assign expire = tick && at_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (tick) begin
            if (at_end) cnt <= '0;
            else        cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/rfp_obligation_ctr.sv
module rfp_obligation_ctr #(
    parameter int MAX_PENDING = 8
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                expire,
    input  logic                                done,
    output logic [$clog2(MAX_PENDING+1)-1:0]    pend,
    output rfp_pkg::rf_backlog_t                blog,
    output logic                                overflow
);
    localparam int PW = $clog2(MAX_PENDING + 1);

    logic up;

    assign blog.full = (pend == PW'(MAX_PENDING));
    assign blog.have = (pend != '0);
    // a completion in the same cycle frees one slot for the new interval
    assign up = expire && (!blog.full || done);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend     <= '0;
            overflow <= 1'b0;
        end else begin
            if (up && !done)      pend <= pend + 1'b1;
            else if (!up && done) pend <= pend - 1'b1;
            if (expire && blog.full && !done) overflow <= 1'b1;
        end
    end
endmodule

// File: rtl/rfp_elapsed_timer.sv
module rfp_elapsed_timer #(
    parameter int RFC_CYCLES = 280,
    parameter int ROWS       = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  step,
    output rfp_pkg::rf_progress_t prog
);
    import rfp_pkg::*;

    localparam int EW = width_of(RFC_CYCLES);
    localparam int Q  = quantum_of(RFC_CYCLES, ROWS);

    logic [EW-1:0]   elapsed;
    logic [ROWS-1:0] hit;

    assign hit[0] = 1'b0;
    generate
        for (genvar k = 1; k < ROWS; k++) begin : g_slot
            assign hit[k] = (elapsed == EW'(k * Q - 1));
        end
    endgenerate

    assign prog.slot = |hit;
    assign prog.last = (elapsed == EW'(RFC_CYCLES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            elapsed <= '0;
        end else if (step) begin
            if (prog.last) elapsed <= '0;
            else           elapsed <= elapsed + 1'b1;
        end
    end
endmodule

// File: rtl/rfp_ctrl.sv
module rfp_ctrl (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tick,
    input  logic                  rd_pend,
    input  logic                  rank_idle,
    input  rfp_pkg::rf_backlog_t  blog,
    input  rfp_pkg::rf_progress_t prog,
    output logic                  step,
    output logic                  done,
    output rfp_pkg::rf_state_e    state
);
    import rfp_pkg::*;

    rf_state_e nxt;
    logic      go;

    // permission to occupy the rank: quiet rank, or backlog at its limit
    assign go   = (rank_idle && !rd_pend) || blog.full;
    assign step = tick && (state == RS_ACTIVE);
    assign done = step && prog.last;

    always_comb begin
        nxt = state;
        if (tick) begin
            unique case (state)
                RS_IDLE:   if (blog.have && go) nxt = RS_ACTIVE;
                RS_ACTIVE: begin
                    if (prog.last)
                        nxt = RS_IDLE;
                    else if (rd_pend && !blog.full && prog.slot)
                        nxt = RS_PAUSED;
                end
                RS_PAUSED: if (go) nxt = RS_ACTIVE;
                default:   nxt = RS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= RS_IDLE;
        else     state <= nxt;
    end
endmodule

// File: rtl/refresh_pause_sched.sv
module refresh_pause_sched #(
    parameter int REFI_CYCLES = 3120,
    parameter int RFC_CYCLES  = 280,
    parameter int ROWS        = 8,
    parameter int MAX_PENDING = 8
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             tick,
    input  logic                             rd_pend,
    input  logic                             rank_idle,
    output logic                             ref_en,
    output logic                             ref_paused,
    output logic                             ref_forced,
    output logic [$clog2(MAX_PENDING+1)-1:0] pend_cnt,
    output logic                             overflow_err
);
    import rfp_pkg::*;

    logic         expire;
    logic         step;
    logic         done;
    rf_backlog_t  blog;
    rf_progress_t prog;
    rf_state_e    state;

    rfp_interval_ctr #(.REFI_CYCLES(REFI_CYCLES)) u_ivl (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .expire (expire)
    );

    rfp_obligation_ctr #(.MAX_PENDING(MAX_PENDING)) u_obl (
        .clk      (clk),
        .rst      (rst),
        .expire   (expire),
        .done     (done),
        .pend     (pend_cnt),
        .blog     (blog),
        .overflow (overflow_err)
    );

    rfp_elapsed_timer #(.RFC_CYCLES(RFC_CYCLES), .ROWS(ROWS)) u_tmr (
        .clk  (clk),
        .rst  (rst),
        .step (step),
        .prog (prog)
    );

    rfp_ctrl u_ctl (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .rd_pend   (rd_pend),
        .rank_idle (rank_idle),
        .blog      (blog),
        .prog      (prog),
        .step      (step),
        .done      (done),
        .state     (state)
    );

    assign ref_en     = (state == RS_ACTIVE);
    assign ref_paused = (state == RS_PAUSED);
    assign ref_forced = ref_en && blog.full;
endmodule

// File: rtl/rfp_sched_chk.sv
module rfp_sched_chk #(
    parameter int MAX_PENDING = 8
) (
    input logic                             clk,
    input logic                             rst,
    input logic                             tick,
    input logic                             rd_pend,
    input logic                             ref_en,
    input logic                             ref_paused,
    input logic                             ref_forced,
    input logic [$clog2(MAX_PENDING+1)-1:0] pend_cnt,
    input logic                             overflow_err
);
    localparam int PW = $clog2(MAX_PENDING + 1);

    a_r5_pause_needs_read: assert property (@(posedge clk) disable iff (rst)
        $rose(ref_paused) |-> $past(rd_pend));

    a_r8_forced_no_pause: assert property (@(posedge clk) disable iff (rst)
        ref_forced |=> !ref_paused);

    a_r10_no_tick_frozen: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ($stable(ref_en) && $stable(pend_cnt) && $stable(ref_paused)));

    a_r9_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
        overflow_err |=> overflow_err);

    a_r11_read_blocks_start: assert property (@(posedge clk) disable iff (rst)
        (!ref_en && rd_pend && pend_cnt < PW'(MAX_PENDING)) |=> !ref_en);

    a_r2_backlog_bound: assert property (@(posedge clk) disable iff (rst)
        pend_cnt <= PW'(MAX_PENDING));
endmodule

bind refresh_pause_sched rfp_sched_chk #(.MAX_PENDING(MAX_PENDING)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .tick         (tick),
    .rd_pend      (rd_pend),
    .ref_en       (ref_en),
    .ref_paused   (ref_paused),
    .ref_forced   (ref_forced),
    .pend_cnt     (pend_cnt),
    .overflow_err (overflow_err)
);

// File: tb/refresh_pause_sched_test.sv
module refresh_pause_sched_test;
    localparam int REFI = 20;
    localparam int RFC  = 16;
    localparam int ROWS = 4;
    localparam int MAXP = 8;
    localparam int Q    = RFC / ROWS;
    localparam int PW   = $clog2(MAXP + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b1, rd_pend = 1'b0, rank_idle = 1'b0;
    logic ref_en, ref_paused, ref_forced, overflow_err;
    logic [PW-1:0] pend_cnt;
    logic f_en, f_paused, f_forced, f_ovf;
    logic [PW-1:0] f_pend;

    int checks = 0, errors = 0, cyc = 0;
    bit cmp_on = 1'b0;

    always #2 clk = ~clk;

    refresh_pause_sched #(.REFI_CYCLES(REFI), .RFC_CYCLES(RFC), .ROWS(ROWS),
                          .MAX_PENDING(MAXP)) uut (
        .clk(clk), .rst(rst), .tick(tick), .rd_pend(rd_pend), .rank_idle(rank_idle),
        .ref_en(ref_en), .ref_paused(ref_paused), .ref_forced(ref_forced),
        .pend_cnt(pend_cnt), .overflow_err(overflow_err));

    refresh_pause_sched #(.REFI_CYCLES(10), .RFC_CYCLES(RFC), .ROWS(ROWS),
                          .MAX_PENDING(MAXP)) uut_fast (
        .clk(clk), .rst(rst), .tick(1'b1), .rd_pend(1'b1), .rank_idle(1'b0),
        .ref_en(f_en), .ref_paused(f_paused), .ref_forced(f_forced),
        .pend_cnt(f_pend), .overflow_err(f_ovf));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // reference model built from the requirements
    int m_ivl, m_pend, m_el, m_st, np;
    bit m_ovf, e, d;
    always @(posedge clk) begin
        if (rst) begin
            m_ivl <= 0; m_pend <= 0; m_el <= 0; m_st <= 0; m_ovf <= 1'b0;
        end else if (tick) begin
            e = (m_ivl == REFI - 1);
            d = (m_st == 1 && m_el == RFC - 1);
            m_ivl <= e ? 0 : m_ivl + 1;
            if (e && m_pend == MAXP && !d) m_ovf <= 1'b1;
            np = m_pend;
            if (d) np--;
            if (e && np < MAXP) np++;
            m_pend <= np;
            case (m_st)
                0: if (m_pend > 0 && ((rank_idle && !rd_pend) || m_pend == MAXP)) m_st <= 1;
                1: begin
                    if (d) begin
                        m_st <= 0; m_el <= 0;
                    end else begin
                        m_el <= m_el + 1;
                        if (rd_pend && m_pend < MAXP && ((m_el + 1) % Q == 0)
                            && (m_el + 1) <= (ROWS - 1) * Q) m_st <= 2;
                    end
                end
                default: if ((rank_idle && !rd_pend) || m_pend == MAXP) m_st <= 1;
            endcase
        end
    end

    always @(negedge clk) begin
        cyc++;
        if (cmp_on && !rst) begin
            chk(ref_en == (m_st == 1), "R3 R4 R5 R7 ref_en vs model", ref_en, m_st == 1);
            chk(ref_paused == (m_st == 2), "R5 ref_paused vs model", ref_paused, m_st == 2);
            chk(int'(pend_cnt) == m_pend, "R2 pend_cnt vs model", pend_cnt, m_pend);
            chk(ref_forced == (m_st == 1 && m_pend == MAXP), "R8 ref_forced vs model",
                ref_forced, m_st == 1 && m_pend == MAXP);
            chk(overflow_err == m_ovf, "R9 overflow vs model", overflow_err, m_ovf);
        end
        if (cyc == 45) chk(f_ovf == 1'b0, "R9 fast no overflow early", f_ovf, 0);
        if (cyc == 160) chk(f_ovf == 1'b1, "R9 fast overflow under load", f_ovf, 1);
    end

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    int run;
    initial begin
        void'($urandom(32'h5EED_1234));
        wait_cyc(3);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(ref_en == 0 && ref_paused == 0 && ref_forced == 0, "R1 outputs low", ref_en, 0);
        chk(pend_cnt == 0 && overflow_err == 0, "R1 counts clear", pend_cnt, 0);
        cmp_on = 1'b1;

        // R2 one obligation per interval, R3 busy rank blocks start
        rank_idle = 1'b0; rd_pend = 1'b0;
        wait_cyc(REFI);
        chk(pend_cnt == 1, "R2 one interval adds one", pend_cnt, 1);
        chk(ref_en == 0, "R3 busy rank does not start", ref_en, 0);

        // R3 start, R4 full length
        rank_idle = 1'b1;
        @(negedge clk);
        chk(ref_en == 1, "R3 idle rank starts refresh", ref_en, 1);
        run = 0;
        while (ref_en) begin run++; @(negedge clk); end
        chk(run == RFC, "R4 uninterrupted length", run, RFC);
        chk(pend_cnt == 0, "R4 obligation retired", pend_cnt, 0);

        // R5 pause at boundary, R6 no pause mid-row, R7 resume length
        rank_idle = 1'b0;
        while (pend_cnt == 0) @(negedge clk);
        rank_idle = 1'b1;
        @(negedge clk);
        rank_idle = 1'b0; rd_pend = 1'b1;
        run = 1;
        @(negedge clk);
        while (ref_en) begin run++; @(negedge clk); end
        chk(run == Q, "R6 read mid-row ignored until boundary", run, Q);
        chk(ref_paused == 1, "R5 paused at first boundary", ref_paused, 1);
        wait_cyc(5);
        chk(ref_paused == 1 && ref_en == 0, "R11 read keeps refresh paused", ref_en, 0);
        rd_pend = 1'b0; rank_idle = 1'b1;
        @(negedge clk);
        chk(ref_en == 1 && ref_paused == 0, "R7 resume raises enable", ref_en, 1);
        run = 0;
        while (ref_en) begin run++; @(negedge clk); end
        chk(run == RFC - Q, "R7 remaining length after resume", run, RFC - Q);

        // R8 forced refresh under read load
        rd_pend = 1'b1; rank_idle = 1'b1;
        while (!ref_en) @(negedge clk);
        chk(pend_cnt == MAXP && ref_forced == 1, "R8 starts only when full", pend_cnt, MAXP);
        run = 0;
        while (ref_en) begin
            run++;
            chk(ref_paused == 0, "R8 forced never paused", ref_paused, 0);
            @(negedge clk);
        end
        chk(run == RFC, "R8 forced runs full length", run, RFC);

        // R10 no strobe freezes everything
        rd_pend = 1'b0;
        wait_cyc(3);
        tick = 1'b0;
        begin
            automatic logic [PW-1:0] p0 = pend_cnt;
            automatic logic e0 = ref_en;
            for (int i = 0; i < 30; i++) begin
                rank_idle = 1'($urandom % 2); rd_pend = 1'($urandom % 2);
                @(negedge clk);
                chk(pend_cnt == p0 && ref_en == e0, "R10 frozen without tick", pend_cnt, p0);
            end
        end
        tick = 1'b1;

        // random mix against the model
        for (int i = 0; i < 4000; i++) begin
            tick      = ($urandom % 8) != 0;
            rd_pend   = ($urandom % 3) == 0;
            rank_idle = ($urandom % 4) != 0;
            @(negedge clk);
        end
        cmp_on = 1'b0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 100000);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule